// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block is an SPI master for mode 0 that moves 8-bit words over SCLK, MOSI and MISO and drives a group of chip-select pins. Chip-select polarity is set per pin by two masks. A configuration mask gives each pin's level while the bus is idle. An active mask travels with every transmit word and gives each pin's level while that word is on the wire. A bit value of 0 drives the pin low and a value of 1 drives it high. To get an active-low select on pin 0, set idle bit 0 to 1 and active bit 0 to 0.

Every word also carries a hold flag. When the flag is set, the chip-selects stay at their active levels after the word ends. The sequencer waits in a holding state and starts the next word from there, so the chip-selects never drop back to their idle levels between words and never glitch. Two programmable gaps, counted in system clocks, set the spacing at each end of a word. The lead gap runs from the chip-selects taking their active levels to the first SCLK edge. The trail gap runs from the last SCLK edge to the chip-selects returning to idle. SCLK is the system clock divided by an even ratio, set as a half-period count.

Top module: `spi_cs_seq`

## Requirements
- R1: While idle, `cs` equals `cfg_idle_cs` one clock after any change to that input; after reset it is all ones until the first idle update.
- R2: From the clock in which a word is accepted until that word ends, `cs` equals the active mask given with the word, with bit i driving pin i.
- R3: SCLK idles low. The first rising SCLK edge of a word comes exactly `cfg_lead_gap + H` clocks after `cs` takes the word's active levels, where H is `cfg_half_div` (0 is read as 1).
- R4: Each word has exactly 8 rising SCLK edges. Every high phase and every low phase between rising edges lasts H clocks.
- R5: MOSI carries the word MSB first. It changes only when SCLK falls, so it is stable at every rising edge.
- R6: MISO is sampled on each rising SCLK edge, MSB first. `rx_data` is shown with a one-clock `rx_valid` pulse in the same clock as the eighth rising edge, once per word.
- R7: After a word whose hold flag is clear, `cs` returns to `cfg_idle_cs` exactly `cfg_trail_gap` clocks after the word's final falling SCLK edge.
- R8: After a word whose hold flag is set, the next word starts straight from the held levels. `cs` makes no transition between the two words, except a direct change to the next word's active mask.
- R9: If no word is offered after a held word, `cs` stays at the held active levels for as long as it takes. It is released only after a later word with the hold flag clear completes.
- R10: `tx_ready` is high only while idle or holding, and SCLK is low whenever `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_idle_cs | input | NCS | Per-pin chip-select level while idle |
| cfg_half_div | input | DIVW | SCLK half period in system clocks (0 read as 1) |
| cfg_lead_gap | input | GAPW | Clocks from chip-select active to the start of the first SCLK half period |
| cfg_trail_gap | input | GAPW | Clocks from the final SCLK fall to chip-select release |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word can be taken (idle or holding) |
| tx_data | input | WORD | Word to shift out, MSB first |
| tx_cs_act | input | NCS | Per-pin chip-select level while this word transfers |
| tx_hold | input | 1 | Keep the chip-selects active after this word |
| rx_valid | output | 1 | One-clock strobe: received word available |
| rx_data | output | WORD | Received word |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | NCS | Chip-select pins |

## Verification
The end of a held word and the acceptance of the next word can fall in the same clock. The bench raises `tx_valid` for the next word while the previous held word is still shifting, so the word is taken on the very first clock of the holding state. The bench judges this by counting every change on `cs` over the whole sequence: exactly two changes when all words share one mask, exactly three when the mask changes between words. It also checks the received bytes in order and requires a single `rx_valid` pulse per word.

// File: rtl/spi_cs_seq_pkg.sv
package spi_cs_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_LEAD  = 3'd1,
        SEQ_SHIFT = 3'd2,
        SEQ_TRAIL = 3'd3,
        SEQ_HOLD  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] half,
    output logic            phase_end
);
    logic [DIVW-1:0] cnt_d, cnt_q;
    logic [DIVW-1:0] limit;

    // a half period of zero behaves as one clock
    assign limit     = (half == '0) ? '0 : half - 1'b1;
    assign phase_end = run && (cnt_q >= limit);

    always_comb begin
        if (!run || phase_end) cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
    parameter int GAPW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [GAPW-1:0] load_val,
    output logic            expired
);
    logic [GAPW-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == '0);

    always_comb begin
        if (load)         cnt_d = load_val;
        else if (expired) cnt_d = '0;
        else              cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_shreg.sv
module spi_shreg #(
    parameter int WORD = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WORD-1:0] load_data,
    input  logic            shift,
    input  logic            sample,
    input  logic            sin,
    output logic            sout,
    output logic [WORD-1:0] rx_next
);
    typedef struct packed {
        logic [WORD-1:0] tx;
        logic [WORD-1:0] rx;
    } sh_t;

    sh_t sh_d, sh_q;

    assign sout    = sh_q.tx[WORD-1];
    assign rx_next = {sh_q.rx[WORD-2:0], sin};

    always_comb begin
        sh_d = sh_q;
        if (load)       sh_d.tx = load_data;
        else if (shift) sh_d.tx = {sh_q.tx[WORD-2:0], 1'b0};
        if (sample)     sh_d.rx = rx_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
    import spi_cs_seq_pkg::*;
#(
    parameter int NCS  = 4,
    parameter int WORD = 8,
    parameter int DIVW = 8,
    parameter int GAPW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCS-1:0]  cfg_idle_cs,
    input  logic [DIVW-1:0] cfg_half_div,
    input  logic [GAPW-1:0] cfg_lead_gap,
    input  logic [GAPW-1:0] cfg_trail_gap,
    input  logic            tx_valid,
    output logic            tx_ready,
    input  logic [WORD-1:0] tx_data,
    input  logic [NCS-1:0]  tx_cs_act,
    input  logic            tx_hold,
    output logic            rx_valid,
    output logic [WORD-1:0] rx_data,
    output logic            sclk,
    output logic            mosi,
    input  logic            miso,
    output logic [NCS-1:0]  cs
);
    localparam int BITW = (WORD > 1) ? $clog2(WORD) : 1;
    localparam logic [BITW-1:0] LAST_BIT = BITW'(WORD - 1);

    typedef struct packed {
        seq_state_e      state;
        logic [NCS-1:0]  cs;
        logic            sclk;
        logic [BITW-1:0] bitcnt;
        logic            hold;
        logic            rx_valid;
        logic [WORD-1:0] rx_data;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        state:    SEQ_IDLE,
        cs:       '1,
        sclk:     1'b0,
        bitcnt:   '0,
        hold:     1'b0,
        rx_valid: 1'b0,
        rx_data:  '0
    };

    seq_t seq_d, seq_q;

    logic            accept;
    logic            phase_end;
    logic            gap_load;
    logic [GAPW-1:0] gap_val;
    logic            gap_expired;
    logic            sh_load, sh_shift, sh_sample;
    logic [WORD-1:0] rx_next;

    assign tx_ready = (seq_q.state == SEQ_IDLE) || (seq_q.state == SEQ_HOLD);
    assign accept   = tx_valid && tx_ready;

    spi_half_timer #(.DIVW(DIVW)) u_half (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (seq_q.state == SEQ_SHIFT),
        .half      (cfg_half_div),
        .phase_end (phase_end)
    );

    spi_gap_timer #(.GAPW(GAPW)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .expired  (gap_expired)
    );

    spi_shreg #(.WORD(WORD)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_data (tx_data),
        .shift     (sh_shift),
        .sample    (sh_sample),
        .sin       (miso),
        .sout      (mosi),
        .rx_next   (rx_next)
    );

    always_comb begin
        seq_d          = seq_q;
        seq_d.rx_valid = 1'b0;
        gap_load       = 1'b0;
        gap_val        = '0;
        sh_load        = 1'b0;
        sh_shift       = 1'b0;
        sh_sample      = 1'b0;

        // a new word starts from idle or straight from the held levels
        if (accept) begin
            sh_load      = 1'b1;
            seq_d.cs     = tx_cs_act;
            seq_d.hold   = tx_hold;
            seq_d.bitcnt = '0;
            seq_d.sclk   = 1'b0;
            if (cfg_lead_gap == '0) begin
                seq_d.state = SEQ_SHIFT;
            end else begin
                seq_d.state = SEQ_LEAD;
                gap_load    = 1'b1;
                gap_val     = cfg_lead_gap - 1'b1;
            end
        end else begin
            unique case (seq_q.state)
                SEQ_IDLE: begin
                    seq_d.cs = cfg_idle_cs;
                end
                SEQ_LEAD: begin
                    if (gap_expired) seq_d.state = SEQ_SHIFT;
                end
                SEQ_SHIFT: begin
                    if (phase_end) begin
                        if (!seq_q.sclk) begin
                            seq_d.sclk = 1'b1;
                            sh_sample  = 1'b1;
                            if (seq_q.bitcnt == LAST_BIT) begin
                                seq_d.rx_valid = 1'b1;
                                seq_d.rx_data  = rx_next;
                            end
                        end else begin
                            seq_d.sclk = 1'b0;
                            if (seq_q.bitcnt != LAST_BIT) begin
                                seq_d.bitcnt = seq_q.bitcnt + 1'b1;
                                sh_shift     = 1'b1;
                            end else if (seq_q.hold) begin
                                seq_d.state = SEQ_HOLD;
                            end else if (cfg_trail_gap == '0) begin
                                seq_d.state = SEQ_IDLE;
                                seq_d.cs    = cfg_idle_cs;
                            end else begin
                                seq_d.state = SEQ_TRAIL;
                                gap_load    = 1'b1;
                                gap_val     = cfg_trail_gap - 1'b1;
                            end
                        end
                    end
                end
                SEQ_TRAIL: begin
                    if (gap_expired) begin
                        seq_d.state = SEQ_IDLE;
                        seq_d.cs    = cfg_idle_cs;
                    end
                end
                SEQ_HOLD: begin
                    // levels of the held word stay on the pins
                end
                default: seq_d.state = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign sclk     = seq_q.sclk;
    assign cs       = seq_q.cs;
    assign rx_valid = seq_q.rx_valid;
    assign rx_data  = seq_q.rx_data;

endmodule

// File: rtl/spi_cs_seq_chk.sv
module spi_cs_seq_chk #(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tx_ready,
    input logic           sclk,
    input logic           mosi,
    input logic           rx_valid,
    input logic [NCS-1:0] cs
);
    AST_READY_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !sclk);  // R10
    AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);  // R6
    AST_RX_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $rose(sclk));  // R6
    AST_MOSI_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));  // R5
    AST_CS_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && $past(!tx_ready)) |-> $stable(cs));  // R2
endmodule

bind spi_cs_seq spi_cs_seq_chk #(.NCS(NCS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_ready (tx_ready),
    .sclk     (sclk),
    .mosi     (mosi),
    .rx_valid (rx_valid),
    .cs       (cs)
);

// File: tb/spi_cs_seq_tb.sv
module spi_cs_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_idle_cs = 4'hF;
    logic [7:0] cfg_half_div = 8'd2;
    logic [7:0] cfg_lead_gap = 8'd0;
    logic [7:0] cfg_trail_gap = 8'd0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] tx_data = 8'h00;
    logic [3:0] tx_cs_act = 4'hF;
    logic       tx_hold = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       sclk, mosi;
    logic       miso = 1'b0;
    logic [3:0] cs;

    always #5 clk = ~clk;

    spi_cs_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_idle_cs(cfg_idle_cs), .cfg_half_div(cfg_half_div),
        .cfg_lead_gap(cfg_lead_gap), .cfg_trail_gap(cfg_trail_gap),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_cs_act(tx_cs_act),
        .tx_hold(tx_hold), .rx_valid(rx_valid), .rx_data(rx_data),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs(cs)
    );

    int errors = 0;
    int checks = 0;

    // monitor state, all sampled at the falling clock edge
    int         cyc = 0;
    logic [3:0] cs_prev = 4'hF;
    logic       sclk_prev = 1'b0;
    logic [3:0] mon_act = 4'hF;
    int         t_cs_act, t_first_rise, t_last_fall, t_last_rise, t_cs_rel;
    int         n_cs_chg, n_rise, bad_phase, bad_cs, rx_cnt;
    bit         first_pending;
    logic [7:0] mosi_sh;
    logic [7:0] rx_hist [4];
    logic [31:0] sl_reg = 32'h0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cs !== cs_prev) begin
                n_cs_chg++;
                if (cs_prev == cfg_idle_cs) begin
                    t_cs_act = cyc;
                    first_pending = 1'b1;
                end
                if (cs == cfg_idle_cs) t_cs_rel = cyc;
            end
            if (sclk && !sclk_prev) begin
                if (first_pending) begin
                    t_first_rise = cyc;
                    first_pending = 1'b0;
                end
                if ((n_rise % 8) != 0 && (cyc - t_last_fall) != int'(cfg_half_div)) bad_phase++;
                if (cs !== mon_act) bad_cs++;
                n_rise++;
                t_last_rise = cyc;
                mosi_sh = {mosi_sh[6:0], mosi};
            end
            if (!sclk && sclk_prev) begin
                if ((cyc - t_last_rise) != int'(cfg_half_div)) bad_phase++;
                t_last_fall = cyc;
                sl_reg = {sl_reg[30:0], 1'b0};
                miso = sl_reg[31];
            end
            if (rx_valid) begin
                if (rx_cnt < 4) rx_hist[rx_cnt] = rx_data;
                rx_cnt++;
            end
        end
        cs_prev = cs;
        sclk_prev = sclk;
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mon_clear(logic [31:0] slave);
        @(negedge clk);
        n_cs_chg = 0; n_rise = 0; bad_phase = 0; bad_cs = 0; rx_cnt = 0;
        first_pending = 1'b0; mosi_sh = 8'h00;
        sl_reg = slave; miso = slave[31];
    endtask

    task automatic send(logic [7:0] d, logic [3:0] act, logic hold);
        @(negedge clk);
        tx_valid = 1'b1; tx_data = d; tx_cs_act = act; tx_hold = hold;
        while (!tx_ready) @(negedge clk);
        mon_act = act;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_done(int n);
        int guard = 0;
        while (!(rx_cnt >= n && tx_ready && cs == cfg_idle_cs) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic set_cfg(int half, int lead, int trail);
        @(negedge clk);
        cfg_half_div = 8'(half); cfg_lead_gap = 8'(lead); cfg_trail_gap = 8'(trail);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 reset cs", int'(cs), 'hF);
        chk("R10 reset ready", int'(tx_ready), 1);
        chk("R3 reset sclk low", int'(sclk), 0);
        chk("R6 reset rx_valid", int'(rx_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_basic();
        set_cfg(2, 0, 0);
        mon_clear(32'h3C00_0000);
        send(8'hA5, 4'hE, 1'b0);
        wait_done(1);
        chk("R5 mosi byte", int'(mosi_sh), 'hA5);
        chk("R6 rx byte", int'(rx_hist[0]), 'h3C);
        chk("R6 one strobe", rx_cnt, 1);
        chk("R4 rise count", n_rise, 8);
        chk("R4 phase length", bad_phase, 0);
        chk("R2 cs at rises", bad_cs, 0);
        chk("R3 lead timing", t_first_rise - t_cs_act, 2);
        chk("R7 trail timing", t_cs_rel - t_last_fall, 0);
        chk("R1 cs back to idle", int'(cs), 'hF);
    endtask

    task automatic t_gaps();
        set_cfg(3, 5, 7);
        mon_clear(32'hC300_0000);
        fork
            send(8'h5A, 4'h7, 1'b0);
            begin
                repeat (3) @(negedge clk);
                chk("R10 ready low in lead gap", int'(tx_ready), 0);
            end
        join
        wait_done(1);
        chk("R5 mosi byte gaps", int'(mosi_sh), 'h5A);
        chk("R6 rx byte gaps", int'(rx_hist[0]), 'hC3);
        chk("R3 lead timing gaps", t_first_rise - t_cs_act, 8);
        chk("R7 trail timing gaps", t_cs_rel - t_last_fall, 7);
        chk("R4 phase length gaps", bad_phase, 0);
    endtask

    task automatic t_hold_chain();
        set_cfg(1, 2, 3);
        mon_clear(32'hDEAD_BE00);
        send(8'h11, 4'hE, 1'b1);
        send(8'h22, 4'hE, 1'b1);
        send(8'h33, 4'hE, 1'b0);
        wait_done(3);
        chk("R8 cs changes in chain", n_cs_chg, 2);
        chk("R6 rx chain 0", int'(rx_hist[0]), 'hDE);
        chk("R6 rx chain 1", int'(rx_hist[1]), 'hAD);
        chk("R6 rx chain 2", int'(rx_hist[2]), 'hBE);
        chk("R5 mosi last chain", int'(mosi_sh), 'h33);
        chk("R4 rises chain", n_rise, 24);
        chk("R7 trail chain", t_cs_rel - t_last_fall, 3);
    endtask

    task automatic t_hold_stall();
        set_cfg(2, 0, 2);
        mon_clear(32'h6600_0000);
        send(8'h81, 4'hD, 1'b1);
        while (rx_cnt < 1) @(negedge clk);
        repeat (30) @(negedge clk);
        chk("R9 cs held while stalled", int'(cs), 'hD);
        chk("R10 ready while holding", int'(tx_ready), 1);
        send(8'h7E, 4'hD, 1'b0);
        wait_done(2);
        chk("R9 cs changes with stall", n_cs_chg, 2);
        chk("R9 released after last", int'(cs), 'hF);
        chk("R6 rx stall 1", int'(rx_hist[1]), 'h00);
        chk("R6 rx stall 0", int'(rx_hist[0]), 'h66);
    endtask

    task automatic t_mask_switch();
        set_cfg(2, 1, 1);
        mon_clear(32'h0000_0000);
        send(8'hF0, 4'hE, 1'b1);
        send(8'h0F, 4'hB, 1'b0);
        wait_done(2);
        chk("R8 direct mask switch", n_cs_chg, 3);
        chk("R2 cs at rises switch", bad_cs, 0);
    endtask

    task automatic t_multi_pin();
        @(negedge clk);
        cfg_idle_cs = 4'h5;
        repeat (2) @(negedge clk);
        chk("R1 idle mask follows config", int'(cs), 'h5);
        set_cfg(4, 3, 0);
        mon_clear(32'h9900_0000);
        send(8'hC6, 4'hA, 1'b0);
        wait_done(1);
        chk("R2 multi pin active", bad_cs, 0);
        chk("R1 multi pin idle", int'(cs), 'h5);
        chk("R3 lead multi pin", t_first_rise - t_cs_act, 7);
        chk("R6 rx multi pin", int'(rx_hist[0]), 'h99);
        @(negedge clk);
        cfg_idle_cs = 4'hF;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_gaps();
        t_hold_chain();
        t_hold_stall();
        t_mask_switch();
        t_multi_pin();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule